// File: doc/BRIEF.md
# SDRAM Controller with Init Sequencer

This block drives a single-bank SDRAM over a 32-bit data path. A host writes a small control register whose low bits pick, one bit per parameter, between a short and a long delay for CAS latency, row-to-column delay, write recovery, precharge time and refresh-to-active time. Each delay in nanoseconds is turned into a whole number of clock cycles from the `CLK_PS` period parameter, rounding up. Two further bits are self-clearing requests. One starts a Precharge All for memory bring-up. The other arms a mode-register load, which takes over the next memory access.

Memory accesses enter on a valid/ready request channel. The block holds `req_ready` low whenever it cannot start a command at the next edge. While `req_ready` is low the requester must keep `req_valid` and the request fields stable. A request is taken on the edge where both are high. Every access uses a closed page: ACTIVE, then one READ or WRITE, then a single-bank PRECHARGE.

The response is a one-cycle `rsp_valid` pulse with no back-pressure. A refresh timer raises an auto refresh at a fixed interval. That refresh wins over a waiting request as soon as the sequencer is idle.

Top module: `sdram_init_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0, `sd_cmd` is NOP (3'b111), `req_ready` is high and `rsp_valid` is low.
- R2: Control bits are [0] CAS latency 3, [1] long row-to-column, [2] long write recovery, [3] long precharge, [4] long refresh-to-active. They are stored on `cfg_we` and read back on `cfg_rdata`. Bits [5] (mode arm) and [6] (init busy) are set by writing 1; writing 0 to them has no effect.
- R3: The column command follows ACTIVE by exactly ceil(25 ns / period) cycles, or ceil(50 ns / period) when bit [1] is set.
- R4: `rsp_valid` pulses exactly CL cycles after READ, with CL 2 or 3 from bit [0], and carries `sd_dq_in` sampled at that edge. A PRECHARGE with `sd_addr[10]`=0 is issued in the same cycle.
- R5: In the WRITE cycle, `sd_dq_oe` is high, `sd_dq_out` holds the request data and `rsp_valid` pulses. PRECHARGE follows after ceil(25 or 50 ns / period) cycles, chosen by bit [2].
- R6: After any PRECHARGE, `req_ready` returns exactly tRP cycles later, with tRP = ceil(25 or 50 ns / period) from bit [3]. The next ACTIVE therefore comes no sooner than tRP+1 cycles after the PRECHARGE.
- R7: Setting bit [6] drops `req_ready` on the next cycle and issues PRECHARGE with `sd_addr[10]`=1 one cycle after that. Bit [6] reads 1 until exactly tRP cycles after that command.
- R8: While idle, auto refreshes (3'b001) are issued every `REFRESH_CYCLES` cycles. A pending refresh is issued ahead of a waiting request. The first command after a refresh comes tRC+1 cycles later, with tRC = ceil(75 or 100 ns / period) from bit [4].
- R9: With bit [5] set, the next accepted request becomes LOAD MODE (3'b000) instead of ACTIVE. `sd_addr` is `req_addr[ROW_W+1:2]`, `rsp_valid` pulses in the same cycle and bit [5] reads 0 from then on.
- R10: `req_ready` is high only when the sequencer is idle, no init is pending and no refresh is pending. The row is `req_addr[ROW_W+COL_W+1:COL_W+2]`, sent with ACTIVE (3'b011). The column is `req_addr[COL_W+1:2]`, sent with READ (3'b101) or WRITE (3'b100). PRECHARGE is 3'b010. Commands are {ras_n, cas_n, we_n}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | Control register write value |
| cfg_rdata | output | 7 | Control register contents |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W+2 | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Transfer acknowledge pulse |
| rsp_rdata | output | DATA_W | Read data |
| sd_cmd | output | 3 | SDRAM command {ras_n, cas_n, we_n} |
| sd_addr | output | ROW_W | SDRAM address bus |
| sd_dq_out | output | DATA_W | Data driven to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DATA_W | Data from memory |

## Verification
A wrong delay count in the sequencer shows up at the ports within one access. The column command, the acknowledge or the PRECHARGE lands a cycle early or late against the ACTIVE, so each gap is measured against values the bench derives from the selected bits. A stuck init or arm flag is visible on the very next control register readback, and it also shows as `req_ready` staying low or as an ACTIVE appearing where LOAD MODE was due. A refresh timer fault appears within one refresh interval, as a wrong gap between two idle refreshes or as an access that starts ahead of a pending refresh.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  // Commands as {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } sd_cmd_e;

  typedef struct packed {
    logic init_busy;  // [6]
    logic mode_arm;   // [5]
    logic rc_long;    // [4]
    logic rp_long;    // [3]
    logic wr_long;    // [2]
    logic rcd_long;   // [1]
    logic cas3;       // [0]
  } sdc_cfg_t;

  // Nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sdc_cfg_reg.sv
module sdc_cfg_reg
  import sdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [6:0] cfg_wdata,
  input  logic       init_done,
  input  logic       mode_done,
  output sdc_cfg_t   cfg
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (cfg_we) begin
        cfg.cas3     <= cfg_wdata[0];
        cfg.rcd_long <= cfg_wdata[1];
        cfg.wr_long  <= cfg_wdata[2];
        cfg.rp_long  <= cfg_wdata[3];
        cfg.rc_long  <= cfg_wdata[4];
      end
      if (mode_done)
        cfg.mode_arm <= 1'b0;
      else if (cfg_we && cfg_wdata[5])
        cfg.mode_arm <= 1'b1;
      if (init_done)
        cfg.init_busy <= 1'b0;
      else if (cfg_we && cfg_wdata[6])
        cfg.init_busy <= 1'b1;
    end
  end

endmodule

// File: rtl/sdc_refresh_tmr.sv
module sdc_refresh_tmr #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic ref_pending
);

  localparam int W = $clog2(INTERVAL + 1);

  logic [W-1:0] cnt;
  logic         tick;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= W'(INTERVAL - 1);
      ref_pending <= 1'b0;
    end else begin
      cnt         <= tick ? W'(INTERVAL - 1) : cnt - 1'b1;
      ref_pending <= tick | (ref_pending & ~ref_ack);
    end
  end

endmodule

// File: rtl/sdc_seq.sv
module sdc_seq
  import sdc_pkg::*;
#(
  parameter int CLK_PS   = 5000,
  parameter int ROW_W    = 12,
  parameter int COL_W    = 8,
  parameter int DATA_W   = 32,
  parameter int TMRD_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  sdc_cfg_t                 cfg,
  input  logic                     ref_pending,
  output logic                     ref_ack,
  output logic                     init_done,
  output logic                     mode_done,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ROW_W+COL_W+1:0]   req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [2:0]               sd_cmd,
  output logic [ROW_W-1:0]         sd_addr,
  output logic [DATA_W-1:0]        sd_dq_out,
  output logic                     sd_dq_oe,
  input  logic [DATA_W-1:0]        sd_dq_in
);

  localparam int TRCD_S = ns_to_cyc(25, CLK_PS);
  localparam int TRCD_L = ns_to_cyc(50, CLK_PS);
  localparam int TWR_S  = ns_to_cyc(25, CLK_PS);
  localparam int TWR_L  = ns_to_cyc(50, CLK_PS);
  localparam int TRP_S  = ns_to_cyc(25, CLK_PS);
  localparam int TRP_L  = ns_to_cyc(50, CLK_PS);
  localparam int TRC_S  = ns_to_cyc(75, CLK_PS);
  localparam int TRC_L  = ns_to_cyc(100, CLK_PS);
  localparam int MAXC   = (TRC_L > TMRD_CYC) ? TRC_L : TMRD_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam logic [ROW_W-1:0] A10_ALL = ROW_W'(1) << 10;

  typedef enum logic [2:0] {
    S_IDLE, S_INIT, S_RFSH, S_ACT, S_RD, S_WREC, S_PRE, S_MRD
  } seq_state_e;

  seq_state_e         state;
  logic [CNT_W-1:0]   cnt;
  logic [2:0]         cmd_q;
  logic [ROW_W-1:0]   addr_q;
  logic [COL_W-1:0]   col_q;
  logic               wr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  dq_out_q;
  logic               dq_oe_q;
  logic               rsp_q;
  logic [DATA_W-1:0]  rdata_q;

  // Delay loads, already reduced by one for the countdown
  logic [CNT_W-1:0] rcd_ld, wr_ld, rp_ld, rc_ld, cl_ld, mrd_ld;
  always_comb begin
    rcd_ld = CNT_W'((cfg.rcd_long ? TRCD_L : TRCD_S) - 1);
    wr_ld  = CNT_W'((cfg.wr_long  ? TWR_L  : TWR_S)  - 1);
    rp_ld  = CNT_W'((cfg.rp_long  ? TRP_L  : TRP_S)  - 1);
    rc_ld  = CNT_W'((cfg.rc_long  ? TRC_L  : TRC_S)  - 1);
    cl_ld  = CNT_W'((cfg.cas3     ? 3      : 2)      - 1);
    mrd_ld = CNT_W'(TMRD_CYC - 1);
  end

  logic accept;
  logic cnt_zero;

  assign cnt_zero  = (cnt == '0);
  assign req_ready = (state == S_IDLE) && !cfg.init_busy && !ref_pending;
  assign accept    = req_valid && req_ready;
  assign ref_ack   = (state == S_IDLE) && !cfg.init_busy && ref_pending;
  assign init_done = (state == S_INIT) && cnt_zero;
  assign mode_done = accept && cfg.mode_arm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      cmd_q    <= CMD_NOP;
      addr_q   <= '0;
      col_q    <= '0;
      wr_q     <= 1'b0;
      wdata_q  <= '0;
      dq_out_q <= '0;
      dq_oe_q  <= 1'b0;
      rsp_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      cmd_q   <= CMD_NOP;
      dq_oe_q <= 1'b0;
      rsp_q   <= 1'b0;
      if (!cnt_zero) cnt <= cnt - 1'b1;

      case (state)
        S_IDLE: begin
          if (cfg.init_busy) begin
            cmd_q  <= CMD_PRE;
            addr_q <= A10_ALL;
            cnt    <= rp_ld;
            state  <= S_INIT;
          end else if (ref_pending) begin
            cmd_q <= CMD_REF;
            cnt   <= rc_ld;
            state <= S_RFSH;
          end else if (accept) begin
            if (cfg.mode_arm) begin
              cmd_q  <= CMD_LMR;
              addr_q <= req_addr[2 +: ROW_W];
              rsp_q  <= 1'b1;
              cnt    <= mrd_ld;
              state  <= S_MRD;
            end else begin
              cmd_q   <= CMD_ACT;
              addr_q  <= req_addr[2+COL_W +: ROW_W];
              col_q   <= req_addr[2 +: COL_W];
              wr_q    <= req_write;
              wdata_q <= req_wdata;
              cnt     <= rcd_ld;
              state   <= S_ACT;
            end
          end
        end
        S_ACT: begin
          if (cnt_zero) begin
            addr_q <= ROW_W'(col_q);
            if (wr_q) begin
              cmd_q    <= CMD_WR;
              dq_oe_q  <= 1'b1;
              dq_out_q <= wdata_q;
              rsp_q    <= 1'b1;
              cnt      <= wr_ld;
              state    <= S_WREC;
            end else begin
              cmd_q <= CMD_RD;
              cnt   <= cl_ld;
              state <= S_RD;
            end
          end
        end
        S_RD: begin
          if (cnt_zero) begin
            rsp_q   <= 1'b1;
            rdata_q <= sd_dq_in;
            cmd_q   <= CMD_PRE;
            addr_q  <= '0;
            cnt     <= rp_ld;
            state   <= S_PRE;
          end
        end
        S_WREC: begin
          if (cnt_zero) begin
            cmd_q  <= CMD_PRE;
            addr_q <= '0;
            cnt    <= rp_ld;
            state  <= S_PRE;
          end
        end
        S_INIT, S_RFSH, S_PRE, S_MRD: begin
          if (cnt_zero) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign sd_cmd    = cmd_q;
  assign sd_addr   = addr_q;
  assign sd_dq_out = dq_out_q;
  assign sd_dq_oe  = dq_oe_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdc_pkg::*;
#(
  parameter int CLK_PS         = 5000,
  parameter int ROW_W          = 12,
  parameter int COL_W          = 8,
  parameter int DATA_W         = 32,
  parameter int REFRESH_CYCLES = 1560,
  parameter int TMRD_CYC       = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [6:0]             cfg_wdata,
  output logic [6:0]             cfg_rdata,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W+1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [2:0]             sd_cmd,
  output logic [ROW_W-1:0]       sd_addr,
  output logic [DATA_W-1:0]      sd_dq_out,
  output logic                   sd_dq_oe,
  input  logic [DATA_W-1:0]      sd_dq_in
);

  sdc_cfg_t cfg_q;
  logic     init_done, mode_done, ref_pending, ref_ack;

  sdc_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .init_done (init_done),
    .mode_done (mode_done),
    .cfg       (cfg_q)
  );

  sdc_refresh_tmr #(.INTERVAL(REFRESH_CYCLES)) u_rtmr (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_ack     (ref_ack),
    .ref_pending (ref_pending)
  );

  sdc_seq #(
    .CLK_PS   (CLK_PS),
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .DATA_W   (DATA_W),
    .TMRD_CYC (TMRD_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg         (cfg_q),
    .ref_pending (ref_pending),
    .ref_ack     (ref_ack),
    .init_done   (init_done),
    .mode_done   (mode_done),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .sd_cmd      (sd_cmd),
    .sd_addr     (sd_addr),
    .sd_dq_out   (sd_dq_out),
    .sd_dq_oe    (sd_dq_oe),
    .sd_dq_in    (sd_dq_in)
  );

  assign cfg_rdata = cfg_q;

endmodule

// File: rtl/sdc_checker.sv
module sdc_checker
  import sdc_pkg::*;
#(
  parameter int CLK_PS = 5000,
  parameter int ROW_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [6:0]       cfg_rdata,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [2:0]       sd_cmd,
  input logic [ROW_W-1:0] sd_addr,
  input logic             sd_dq_oe
);

  localparam int TRCD_S = ns_to_cyc(25, CLK_PS);
  localparam int TRCD_L = ns_to_cyc(50, CLK_PS);

  logic [7:0] since_act;
  logic [7:0] rcd_need;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= '0;
      rcd_need  <= '0;
    end else if (sd_cmd == CMD_ACT) begin
      since_act <= 8'd1;
      rcd_need  <= cfg_rdata[1] ? 8'(TRCD_L) : 8'(TRCD_S);
    end else if (since_act != 8'hFF) begin
      since_act <= since_act + 8'd1;
    end
  end

  // R3: column command never earlier than the selected row-to-column delay
  a_r3_rcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == CMD_RD || sd_cmd == CMD_WR) |-> since_act >= rcd_need);

  // R5: the data bus is driven only with a WRITE command
  a_r5_oe_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> sd_cmd == CMD_WR);

  // R4: the acknowledge is a single-cycle pulse
  a_r4_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7: no request is taken while init is pending
  a_r7_init_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[6] |-> !req_ready);

  // R7: an all-bank precharge only happens under init
  a_r7_pall_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == CMD_PRE && sd_addr[10]) |-> cfg_rdata[6]);

  // R9: the arm bit is already clear when LOAD MODE appears
  a_r9_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == CMD_LMR) |-> !cfg_rdata[5]);

endmodule

bind sdram_init_ctrl sdc_checker #(.CLK_PS(CLK_PS), .ROW_W(ROW_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_rdata (cfg_rdata),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .sd_cmd    (sd_cmd),
  .sd_addr   (sd_addr),
  .sd_dq_oe  (sd_dq_oe)
);

// File: tb/sdram_init_ctrl_tb.sv
`timescale 1ns/1ps
module sdram_init_ctrl_tb;

  localparam int PER_PS = 5000;
  localparam int REFI   = 800;

  localparam logic [2:0] C_LMR = 3'b000, C_REF = 3'b001, C_PRE = 3'b010,
                         C_ACT = 3'b011, C_WR = 3'b100, C_RD = 3'b101,
                         C_NOP = 3'b111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_wdata = '0;
  logic [6:0]  cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [2:0]  sd_cmd;
  logic [11:0] sd_addr;
  logic [31:0] sd_dq_out;
  logic        sd_dq_oe;
  logic [31:0] sd_dq_in = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_init_ctrl #(.CLK_PS(PER_PS), .REFRESH_CYCLES(REFI)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sd_cmd(sd_cmd),
    .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in)
  );

  function automatic int cyc(input int ns);
    return (ns * 1000 + PER_PS - 1) / PER_PS;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic write_cfg(input logic [6:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wait_ref();
    int n = 0;
    do begin @(negedge clk); n++; end while (sd_cmd != C_REF && n < 3000);
  endtask

  task automatic wait_ready(output int k);
    k = 0;
    while (!req_ready && k < 3000) begin @(negedge clk); k++; end
  endtask

  task automatic wait_cmd(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (sd_cmd == C_NOP && k < 3000);
  endtask

  // Stimulus vectors: control bits, direction, address, data
  localparam int NV = 8;
  localparam logic [4:0]  V_CFG  [NV] = '{5'b00000, 5'b00001, 5'b00010, 5'b00100,
                                          5'b00011, 5'b01000, 5'b11111, 5'b00000};
  localparam bit          V_WR   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [21:0] V_ADDR [NV] = '{22'h001234, 22'h3FFFFC, 22'h000400, 22'h2AA554,
                                          22'h155AA8, 22'h0003FC, 22'h100000, 22'h3C0F0C};
  localparam logic [31:0] V_DATA [NV] = '{32'hA5A50001, 32'h0F0F1234, 32'hDEADBEEF, 32'h00000000,
                                          32'hFFFFFFFF, 32'h13579BDF, 32'h80000001, 32'h2468ACE0};

  task automatic do_access(input logic [4:0] c, input bit wr, input logic [21:0] a,
                           input logic [31:0] d);
    int k;
    int rcd, twr, trp, cl;
    rcd = cyc(c[1] ? 50 : 25);
    twr = cyc(c[2] ? 50 : 25);
    trp = cyc(c[3] ? 50 : 25);
    cl  = c[0] ? 3 : 2;
    write_cfg({2'b00, c});
    chk(cfg_rdata == {2'b00, c}, "R2 cfg readback", cfg_rdata, {2'b00, c});
    wait_ref();
    wait_ready(k);
    sd_dq_in  = ~d;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(sd_cmd == C_ACT && sd_addr == a[21:10], "R10 ACTIVE row",
        {sd_cmd, sd_addr}, {C_ACT, a[21:10]});
    wait_cmd(k);
    chk(k == rcd, "R3 row-to-column gap", k, rcd);
    chk(sd_cmd == (wr ? C_WR : C_RD) && sd_addr == {4'h0, a[9:2]}, "R10 column cmd",
        {sd_cmd, sd_addr}, {(wr ? C_WR : C_RD), 4'h0, a[9:2]});
    if (wr) begin
      chk(sd_dq_oe && sd_dq_out == d && rsp_valid, "R5 write data and ack",
          {sd_dq_oe, rsp_valid, sd_dq_out}, {2'b11, d});
      wait_cmd(k);
      chk(k == twr, "R5 write recovery", k, twr);
      chk(sd_cmd == C_PRE && !sd_addr[10], "R5 precharge", {sd_cmd, sd_addr[10]}, {C_PRE, 1'b0});
    end else begin
      k = 0;
      do begin @(negedge clk); k++; end while (!rsp_valid && k < 50);
      chk(k == cl, "R4 CAS latency", k, cl);
      chk(rsp_rdata == ~d, "R4 read data", rsp_rdata, ~d);
      chk(sd_cmd == C_PRE && !sd_addr[10], "R4 precharge", {sd_cmd, sd_addr[10]}, {C_PRE, 1'b0});
    end
    wait_ready(k);
    chk(k == trp, "R6 precharge to ready", k, trp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 7'h00, "R1 cfg after reset", cfg_rdata, 0);
    chk(sd_cmd == C_NOP, "R1 NOP after reset", sd_cmd, C_NOP);
    chk(req_ready && !rsp_valid, "R1 ready/ack after reset", {req_ready, rsp_valid}, 2'b10);

    // R7 init with long precharge
    write_cfg(7'b1001000);
    chk(cfg_rdata[6] == 1'b1, "R7 init bit set", cfg_rdata[6], 1);
    chk(!req_ready, "R7 ready held off", req_ready, 0);
    @(negedge clk);
    chk(sd_cmd == C_PRE && sd_addr[10], "R7 precharge all", {sd_cmd, sd_addr[10]}, {C_PRE, 1'b1});
    k = 0;
    do begin @(negedge clk); k++; end while (cfg_rdata[6] && k < 100);
    chk(k == cyc(50), "R7 init busy length", k, cyc(50));

    // Vector walk (R3, R4, R5, R6, R10)
    for (int i = 0; i < NV; i++) do_access(V_CFG[i], V_WR[i], V_ADDR[i], V_DATA[i]);

    // R9 armed mode load, then normal access
    write_cfg(7'b0100001);
    chk(cfg_rdata[5] == 1'b1, "R9 arm bit set", cfg_rdata[5], 1);
    wait_ref();
    wait_ready(k);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {8'h00, 12'h032, 2'b00};
    @(negedge clk);
    req_valid = 1'b0;
    chk(sd_cmd == C_LMR && sd_addr == 12'h032, "R9 load mode opcode",
        {sd_cmd, sd_addr}, {C_LMR, 12'h032});
    chk(rsp_valid && !cfg_rdata[5], "R9 ack and arm clear", {rsp_valid, cfg_rdata[5]}, 2'b10);
    do_access(5'b00001, 1'b0, 22'h0ABCD4, 32'h11223344);

    // R2 writing zero to arm/init leaves them clear
    write_cfg(7'b0011111);
    chk(cfg_rdata == 7'b0011111, "R2 zero to self-clearing bits", cfg_rdata, 7'b0011111);

    // R8 refresh interval while idle
    wait_ref();
    k = 0;
    do begin @(negedge clk); k++; end while (sd_cmd != C_REF && k < 3000);
    chk(k == REFI, "R8 refresh interval", k, REFI);

    // R8 refresh wins over waiting request; tRC long (bit 4 set above)
    wait_ready(k);
    k = 0;
    while (req_ready && k < 3000) begin @(negedge clk); k++; end
    req_valid = 1'b1; req_write = 1'b0; req_addr = 22'h000010;
    @(negedge clk);
    chk(sd_cmd == C_REF, "R8 refresh priority", sd_cmd, C_REF);
    wait_cmd(k);
    req_valid = 1'b0;
    chk(k == cyc(100) + 1 && sd_cmd == C_ACT, "R8 refresh to active", k, cyc(100) + 1);
    k = 0;
    do begin @(negedge clk); k++; end while (!rsp_valid && k < 100);
    wait_ready(k);

    done = 1'b1;
    report();
  end

endmodule